// File: doc/BRIEF.md
# Instruction Access Exception Checker

This block screens one decoded instruction against the current processor-status mode bits and reports the single access exception that the instruction raises, if any. It looks at eight instruction attributes: a VLIW packing-constraint violation, non-excepting form, conditional form, floating-point operation, media operation, floating-point register access, privileged operation, and the media-trap instruction. It also looks at five status bits: non-excepting mode, conditional mode, floating-point enable, media enable and supervisor. Six checks are tried in a fixed order, and the first check whose condition holds decides the outcome. An earlier check can also decide that nothing is raised, which ends the search.

The inputs are sampled when `in_valid` is high. The outcome appears on the registered outputs one clock later. A small two-state controller sequences this. In state `S_IDLE` the outputs are quiet. When `in_valid` is high, the controller moves to `S_SHOW`, from either state, and holds the new outcome there for one cycle. When `in_valid` is low, it moves from `S_SHOW` (or stays) to `S_IDLE`.

A parameter `HAS_FP_EXC` selects the full variant (1) or a reduced variant (0). The full variant redirects float and media instructions to floating-point exceptions or to a media status note. The reduced variant reports illegal-instruction in those cases.

Top module: `iaccess_exc_check`

## Requirements
- R1: After reset, and until the first accepted input, `out_valid` and `trap` are 0 and `kind` is 0.
- R2: An input accepted with `in_valid`=1 at a rising edge is reported at the next rising edge with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`=0, `trap`=0 and `kind`=0 one cycle later.
- R3: `kind` codes are 0 none, 1 illegal-instruction, 2 FP-disabled, 3 media-disabled, 4 privileged-instruction, 5 FP exception of sequence-error type, 6 FP exception of unimplemented-op type, and 7 media status note (unimplemented media op recorded, no trap). `trap`=1 exactly for codes 1 to 6.
- R4: A constraint violation gives code 1. In the full variant, a float or media instruction with a constraint violation gives code 5 instead.
- R5: A non-excepting instruction while non-excepting mode is off gives the not-implemented outcome. In the full variant this is code 6 if the instruction is float, otherwise code 7 if it is media. Every other case gives code 1.
- R6: A conditional instruction while conditional mode is off gives the same not-implemented outcome as R5.
- R7: With FP enable off, the result is code 2 if the instruction is float, or if it accesses FP registers while media enable is also off. Otherwise the result is code 0, and no later check applies.
- R8: With media enable off, a media instruction or the media-trap instruction gives code 3. Otherwise the result is code 0, and the privilege check does not apply.
- R9: A privileged instruction gives code 4 only when the supervisor bit is 0. With supervisor set, it gives code 0.
- R10: Checks are applied in the order R4, R5, R6, R7, R8, R9. The first one whose condition holds decides the result.
- R11: With `HAS_FP_EXC`=0, codes 5, 6 and 7 never occur. Each of those cases gives code 1 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction and status are presented this cycle |
| a_cv | input | 1 | Packing-constraint violation |
| a_nonexc | input | 1 | Non-excepting instruction |
| a_cond | input | 1 | Conditional instruction |
| a_float | input | 1 | Floating-point instruction |
| a_media | input | 1 | Media instruction |
| a_fpreg | input | 1 | Instruction accesses FP registers |
| a_priv | input | 1 | Privileged instruction |
| a_mtrap | input | 1 | Media-trap instruction |
| s_ne_on | input | 1 | Non-excepting mode enabled |
| s_cond_on | input | 1 | Conditional mode enabled |
| s_fp_on | input | 1 | FP unit enabled |
| s_media_on | input | 1 | Media unit enabled |
| s_super | input | 1 | Supervisor mode |
| out_valid | output | 1 | Result of the previous cycle's input |
| trap | output | 1 | An exception is raised |
| kind | output | 3 | Outcome code (see R3) |

## Verification
The assertions check the timing rules on every cycle. An accepted input is always followed by `out_valid`, and an idle cycle is always followed by quiet outputs. They also check several properties that must hold for any input: a constraint violation always traps with code 1 or 5, supervisor mode never yields code 4, a disabled FP unit never yields codes 3 or 4, and the reduced variant never produces codes 5 to 7. The full priority ordering cannot be covered by such properties, nor can the float/media/integer split of the not-implemented outcome. The bench's exhaustive sweep over all 8192 attribute and status combinations, run on both variants, is what shows those.

// File: rtl/iae_pkg.sv
package iae_pkg;

    localparam int KIND_W   = 3;
    localparam int N_ATTR   = 8;
    localparam int N_STATUS = 5;

    typedef enum logic [KIND_W-1:0] {
        K_NONE      = 3'd0,
        K_ILLEGAL   = 3'd1,
        K_FP_DIS    = 3'd2,
        K_MED_DIS   = 3'd3,
        K_PRIV      = 3'd4,
        K_FP_SEQ    = 3'd5,
        K_FP_UNIMPL = 3'd6,
        K_MED_NOTE  = 3'd7
    } exc_kind_e;

    typedef struct packed {
        logic cv;
        logic nonexc;
        logic cond;
        logic flt;
        logic med;
        logic fpreg;
        logic priv;
        logic mtrap;
    } insn_attr_t;

    typedef struct packed {
        logic ne_on;
        logic cond_on;
        logic fp_on;
        logic med_on;
        logic super_m;
    } mode_bits_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_SHOW = 1'b1
    } phase_e;

    function automatic logic kind_traps(exc_kind_e k);
        return (k != K_NONE) && (k != K_MED_NOTE);
    endfunction

endpackage

// File: rtl/iae_redirect.sv
module iae_redirect
    import iae_pkg::*;
#(
    parameter bit HAS_FP_EXC = 1'b1
) (
    input  logic      flt,
    input  logic      med,
    output exc_kind_e kind_violation,
    output exc_kind_e kind_unimpl
);

    generate
        if (HAS_FP_EXC) begin : g_full
            always_comb begin
                kind_violation = (flt || med) ? K_FP_SEQ : K_ILLEGAL;
                if (flt)
                    kind_unimpl = K_FP_UNIMPL;
                else if (med)
                    kind_unimpl = K_MED_NOTE;
                else
                    kind_unimpl = K_ILLEGAL;
            end
        end else begin : g_reduced
            always_comb begin
                kind_violation = K_ILLEGAL;
                kind_unimpl    = K_ILLEGAL;
            end
        end
    endgenerate

endmodule

// File: rtl/iae_prio.sv
module iae_prio
    import iae_pkg::*;
(
    input  insn_attr_t attr,
    input  mode_bits_t mode,
    input  exc_kind_e  kind_violation,
    input  exc_kind_e  kind_unimpl,
    output exc_kind_e  kind
);

    logic hit_cv, hit_ne, hit_cond, hit_fp, hit_med, hit_priv;

    always_comb begin
        hit_cv   = attr.cv;
        hit_ne   = attr.nonexc && !mode.ne_on;
        hit_cond = attr.cond && !mode.cond_on;
        hit_fp   = !mode.fp_on;
        hit_med  = !mode.med_on;
        hit_priv = attr.priv && !mode.super_m;
    end

    // first matching stage decides; FP and media stages may decide "none"
    always_comb begin
        if (hit_cv)
            kind = kind_violation;
        else if (hit_ne || hit_cond)
            kind = kind_unimpl;
        else if (hit_fp)
            kind = (attr.flt || (attr.fpreg && !mode.med_on)) ? K_FP_DIS : K_NONE;
        else if (hit_med)
            kind = (attr.med || attr.mtrap) ? K_MED_DIS : K_NONE;
        else if (hit_priv)
            kind = K_PRIV;
        else
            kind = K_NONE;
    end

endmodule

// File: rtl/iaccess_exc_check.sv
module iaccess_exc_check
    import iae_pkg::*;
#(
    parameter bit HAS_FP_EXC = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        a_cv,
    input  logic        a_nonexc,
    input  logic        a_cond,
    input  logic        a_float,
    input  logic        a_media,
    input  logic        a_fpreg,
    input  logic        a_priv,
    input  logic        a_mtrap,
    input  logic        s_ne_on,
    input  logic        s_cond_on,
    input  logic        s_fp_on,
    input  logic        s_media_on,
    input  logic        s_super,
    output logic        out_valid,
    output logic        trap,
    output logic [2:0]  kind
);

    insn_attr_t attr;
    mode_bits_t mode;
    exc_kind_e  k_viol, k_unimpl, k_next, k_q;
    phase_e     state_q, state_d;

    always_comb begin
        attr = '{cv: a_cv, nonexc: a_nonexc, cond: a_cond, flt: a_float,
                 med: a_media, fpreg: a_fpreg, priv: a_priv, mtrap: a_mtrap};
        mode = '{ne_on: s_ne_on, cond_on: s_cond_on, fp_on: s_fp_on,
                 med_on: s_media_on, super_m: s_super};
    end

    iae_redirect #(.HAS_FP_EXC(HAS_FP_EXC)) u_redirect (
        .flt            (a_float),
        .med            (a_media),
        .kind_violation (k_viol),
        .kind_unimpl    (k_unimpl)
    );

    iae_prio u_prio (
        .attr           (attr),
        .mode           (mode),
        .kind_violation (k_viol),
        .kind_unimpl    (k_unimpl),
        .kind           (k_next)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = in_valid ? S_SHOW : S_IDLE;
            S_SHOW: state_d = in_valid ? S_SHOW : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            k_q     <= K_NONE;
        end else begin
            state_q <= state_d;
            k_q     <= in_valid ? k_next : K_NONE;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        trap      = 1'b0;
        kind      = K_NONE;
        unique case (state_q)
            S_IDLE: ;
            S_SHOW: begin
                out_valid = 1'b1;
                kind      = k_q;
                trap      = kind_traps(k_q);
            end
            default: ;
        endcase
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap && kind == 3'd0));

    p_violation_traps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_cv) |=> (trap && (kind == 3'd1 || kind == 3'd5)));

    p_fp_off_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !s_fp_on) |=> (kind != 3'd3 && kind != 3'd4));

    p_super_no_priv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && s_super) |=> (kind != 3'd4));

    generate
        if (!HAS_FP_EXC) begin : g_reduced_chk
            p_reduced_r11: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (kind <= 3'd4));
        end
    endgenerate

endmodule

// File: tb/sim_iaccess_exc_check.sv
`timescale 1ns/1ps
module sim_iaccess_exc_check;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [12:0] vec = '0;
    logic ov0, tr0, ov1, tr1;
    logic [2:0] k0, k1;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    iaccess_exc_check #(.HAS_FP_EXC(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_cv(vec[0]), .a_nonexc(vec[1]), .a_cond(vec[2]), .a_float(vec[3]),
        .a_media(vec[4]), .a_fpreg(vec[5]), .a_priv(vec[6]), .a_mtrap(vec[7]),
        .s_ne_on(vec[8]), .s_cond_on(vec[9]), .s_fp_on(vec[10]),
        .s_media_on(vec[11]), .s_super(vec[12]),
        .out_valid(ov0), .trap(tr0), .kind(k0));

    iaccess_exc_check #(.HAS_FP_EXC(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_cv(vec[0]), .a_nonexc(vec[1]), .a_cond(vec[2]), .a_float(vec[3]),
        .a_media(vec[4]), .a_fpreg(vec[5]), .a_priv(vec[6]), .a_mtrap(vec[7]),
        .s_ne_on(vec[8]), .s_cond_on(vec[9]), .s_fp_on(vec[10]),
        .s_media_on(vec[11]), .s_super(vec[12]),
        .out_valid(ov1), .trap(tr1), .kind(k1));

    // expected kind per R3..R11
    function automatic logic [2:0] exp_kind(input logic [12:0] v, input bit full);
        if (v[0]) return (full && (v[3] || v[4])) ? 3'd5 : 3'd1;       // R4
        if ((v[1] && !v[8]) || (v[2] && !v[9])) begin                    // R5 R6
            if (full && v[3]) return 3'd6;
            if (full && v[4]) return 3'd7;
            return 3'd1;
        end
        if (!v[10]) return (v[3] || (v[5] && !v[11])) ? 3'd2 : 3'd0;     // R7
        if (!v[11]) return (v[4] || v[7]) ? 3'd3 : 3'd0;                 // R8
        if (v[6] && !v[12]) return 3'd4;                                 // R9
        return 3'd0;
    endfunction

    function automatic string tag_of(input logic [12:0] v, input bit full);
        int hits;
        string t;
        hits = int'(v[0]) + int'(v[1] && !v[8]) + int'(v[2] && !v[9]) + int'(!v[10])
             + int'(!v[11]) + int'(v[6] && !v[12]);
        if (v[0]) t = "R4";
        else if (v[1] && !v[8]) t = "R5";
        else if (v[2] && !v[9]) t = "R6";
        else if (!v[10]) t = "R7";
        else if (!v[11]) t = "R8";
        else t = "R9";
        if (!full) t = {t, "/R11"};
        if (hits > 1) t = {t, "/R10"};
        return t;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_inst(input logic [12:0] v, input bit full,
                              input logic ov, input logic tr, input logic [2:0] k);
        logic [2:0] ek;
        ek = exp_kind(v, full);
        check("R2", int'(ov), 1);
        check(tag_of(v, full), int'(k), int'(ek));
        check("R3", int'(tr), int'(ek != 3'd0 && ek != 3'd7));
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        if (!finished) $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(ov0), 0); check("R1", int'(tr0), 0); check("R1", int'(k0), 0);
        check("R1", int'(ov1), 0); check("R1", int'(k1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(ov0), 0); check("R1", int'(k0), 0);

        for (int i = 0; i < 8192; i++) begin
            vec = 13'(i);
            in_valid = 1'b1;
            @(negedge clk);
            check_inst(vec, 1'b1, ov0, tr0, k0);
            check_inst(vec, 1'b0, ov1, tr1, k1);
            if (i % 16 == 5) begin
                // R2: inputs held, strobe dropped; outputs must clear
                in_valid = 1'b0;
                @(negedge clk);
                check("R2", int'(ov0), 0); check("R2", int'(tr0), 0);
                check("R2", int'(k0), 0); check("R2", int'(ov1), 0);
                check("R2", int'(k1), 0);
            end
        end

        // R9: privileged in supervisor with all enables on
        vec = 13'b1_1111_0100_0000;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9", int'(k0), 0);
        vec[12] = 1'b0;
        @(negedge clk);
        check("R9", int'(k0), 4);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", int'(ov0), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule